// File: doc/BRIEF.md
# Two-Road Crossing Light Controller

This block sequences the signals at a junction of two roads, A and B. It is a Moore machine with four states. One road keeps green for as long as its own traffic sensor is high. When that sensor drops, the road passes through one period of yellow, and then green moves to the other road. The second road follows the same hold-then-yield rule, and afterwards control returns to road A.

The clock period is the yellow interval, nominally five seconds. Every state therefore lasts at least one clock period. The light outputs are decoded only from the registered state. The current state code is also brought out, so that the sequence can be observed directly.

Top module: `tl_crossing_ctrl`

## Requirements
- R1: While `rst_n` is low, the state is 00, `light_a` is green (00) and `light_b` is red (10). After release, the machine starts from that state.
- R2: In state 00, a high `sense_a` keeps the machine in state 00 on the next rising edge, whatever the value of `sense_b`.
- R3: In state 00, a low `sense_a` moves the machine to state 01 on the next rising edge, whatever the value of `sense_b`.
- R4: State 01 always moves to state 10 on the next rising edge. Both sensors have no effect there.
- R5: In state 10, a high `sense_b` keeps the machine in state 10 on the next rising edge, whatever the value of `sense_a`.
- R6: In state 10, a low `sense_b` moves the machine to state 11 on the next rising edge, whatever the value of `sense_a`.
- R7: State 11 always moves to state 00 on the next rising edge. Both sensors have no effect there.
- R8: The lights depend only on the state, using green=00, yellow=01 and red=10 for the pair (A, B): state 00 gives (00, 10), 01 gives (01, 10), 10 gives (10, 00), and 11 gives (10, 01).
- R9: Neither light output ever shows code 11, and at least one road is red in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; its period is the yellow time |
| rst_n | input | 1 | Asynchronous active-low reset |
| sense_a | input | 1 | Road A traffic present |
| sense_b | input | 1 | Road B traffic present |
| light_a | output | 2 | Road A light code |
| light_b | output | 2 | Road B light code |
| state_o | output | 2 | Current state code |

## Verification
On every cycle, assertions check each state transition, including the forced steps out of the two yellow states. They also check that the outputs never carry the illegal light code and never show two roads off red at once. Only the bench scenarios can show that the design follows the full intended sequence. These scenarios include long green holds on both roads, sensor toggling on the road that is waiting, and a reset applied in the middle of a cycle. In each case the bench compares the design with an independent model on every clock.

// File: rtl/tl_pkg.sv
package tl_pkg;
  localparam int STATE_W = 2;
  localparam int LIGHT_W = 2;

  typedef enum logic [STATE_W-1:0] {
    ST_A_GO   = 2'b00,
    ST_A_WARN = 2'b01,
    ST_B_GO   = 2'b10,
    ST_B_WARN = 2'b11
  } tl_state_e;

  typedef enum logic [LIGHT_W-1:0] {
    LT_GREEN  = 2'b00,
    LT_YELLOW = 2'b01,
    LT_RED    = 2'b10
  } tl_light_e;
endpackage

// File: rtl/tl_next_state.sv
module tl_next_state
  import tl_pkg::*;
(
  input  tl_state_e cur_st,
  input  logic      sense_a,
  input  logic      sense_b,
  output tl_state_e nxt_st
);
  always_comb begin
    nxt_st = cur_st;
    unique case (cur_st)
      ST_A_GO:   nxt_st = sense_a ? ST_A_GO : ST_A_WARN;
      ST_A_WARN: nxt_st = ST_B_GO;
      ST_B_GO:   nxt_st = sense_b ? ST_B_GO : ST_B_WARN;
      ST_B_WARN: nxt_st = ST_A_GO;
      default:   nxt_st = ST_A_GO;
    endcase
  end
endmodule

// File: rtl/tl_state_reg.sv
module tl_state_reg
  import tl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      en,
  input  tl_state_e nxt_st,
  output tl_state_e cur_st
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur_st <= ST_A_GO;
    else if (en) cur_st <= nxt_st;
  end
endmodule

// File: rtl/tl_light_decode.sv
module tl_light_decode
  import tl_pkg::*;
(
  input  tl_state_e cur_st,
  output tl_light_e lamp_a,
  output tl_light_e lamp_b
);
  always_comb begin
    lamp_a = LT_RED;
    lamp_b = LT_RED;
    unique case (cur_st)
      ST_A_GO:   begin lamp_a = LT_GREEN;  lamp_b = LT_RED;    end
      ST_A_WARN: begin lamp_a = LT_YELLOW; lamp_b = LT_RED;    end
      ST_B_GO:   begin lamp_a = LT_RED;    lamp_b = LT_GREEN;  end
      ST_B_WARN: begin lamp_a = LT_RED;    lamp_b = LT_YELLOW; end
      default:   begin lamp_a = LT_RED;    lamp_b = LT_RED;    end
    endcase
  end
endmodule

// File: rtl/tl_crossing_ctrl.sv
module tl_crossing_ctrl
  import tl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sense_a,
  input  logic               sense_b,
  output logic [LIGHT_W-1:0] light_a,
  output logic [LIGHT_W-1:0] light_b,
  output logic [STATE_W-1:0] state_o
);
  tl_state_e cur_st, nxt_st;
  tl_light_e lamp_a, lamp_b;
  logic      step_en;

  assign step_en = 1'b1;

  tl_next_state u_next (
    .cur_st (cur_st),
    .sense_a(sense_a),
    .sense_b(sense_b),
    .nxt_st (nxt_st)
  );

  tl_state_reg u_reg (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (step_en),
    .nxt_st(nxt_st),
    .cur_st(cur_st)
  );

  tl_light_decode u_dec (
    .cur_st(cur_st),
    .lamp_a(lamp_a),
    .lamp_b(lamp_b)
  );

  assign light_a = lamp_a;
  assign light_b = lamp_b;
  assign state_o = cur_st;

  assert_a_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00 && sense_a) |=> state_o == 2'b00);
  assert_a_yield_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b00 && !sense_a) |=> state_o == 2'b01);
  assert_a_warn_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b01) |=> state_o == 2'b10);
  assert_b_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10 && sense_b) |=> state_o == 2'b10);
  assert_b_yield_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b10 && !sense_b) |=> state_o == 2'b11);
  assert_b_warn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'b11) |=> state_o == 2'b00);
  assert_no_bad_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (light_a != 2'b11) && (light_b != 2'b11));
  assert_one_red_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (light_a == 2'b10) || (light_b == 2'b10));
  assert_stable_lights_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(state_o) |-> ($stable(light_a) && $stable(light_b)));
endmodule

// File: tb/tl_crossing_ctrl_bench.sv
module tl_crossing_ctrl_bench;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sense_a, sense_b;
  logic [1:0] light_a, light_b, state_o;

  int checks = 0;
  int fails  = 0;
  int model_st = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tl_crossing_ctrl u_tl_crossing_ctrl (
    .clk(clk), .rst_n(rst_n), .sense_a(sense_a), .sense_b(sense_b),
    .light_a(light_a), .light_b(light_b), .state_o(state_o)
  );

  function automatic int exp_a(int s);
    if (s == 0) return 0;
    if (s == 1) return 1;
    return 2;
  endfunction

  function automatic int exp_b(int s);
    if (s == 2) return 0;
    if (s == 3) return 1;
    return 2;
  endfunction

  task automatic check(string tag);
    checks++;
    if (int'(state_o) != model_st || int'(light_a) != exp_a(model_st) ||
        int'(light_b) != exp_b(model_st)) begin
      fails++;
      $display("FAIL %s: state=%0d la=%0d lb=%0d expected state=%0d la=%0d lb=%0d",
               tag, state_o, light_a, light_b, model_st, exp_a(model_st), exp_b(model_st));
    end
    checks++;
    if (light_a == 2'b11 || light_b == 2'b11 || (light_a != 2'b10 && light_b != 2'b10)) begin
      fails++;
      $display("FAIL R9: la=%0d lb=%0d expected no 11 code and one road red", light_a, light_b);
    end
  endtask

  // one clock: drive at negedge, advance model at posedge, compare at next negedge
  task automatic step(input logic ta, input logic tb, input string tag);
    sense_a = ta;
    sense_b = tb;
    @(posedge clk);
    case (model_st)
      0: model_st = ta ? 0 : 1;
      1: model_st = 2;
      2: model_st = tb ? 2 : 3;
      default: model_st = 0;
    endcase
    @(negedge clk);
    check(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] lfsr;
    rst_n = 1'b0; sense_a = 1'b1; sense_b = 1'b0;
    repeat (3) @(negedge clk);
    model_st = 0;
    check("R1 reset");
    rst_n = 1'b1;
    // R2: long hold of A with B toggling
    for (int i = 0; i < 25; i++) step(1'b1, i[0], "R2 hold A, B ignored");
    step(1'b0, 1'b1, "R3 A drops");
    step(1'b1, 1'b0, "R4 A yellow ignores sensors");
    // R5: long hold of B with A toggling
    for (int i = 0; i < 20; i++) step(i[1], 1'b1, "R5 hold B, A ignored");
    step(1'b1, 1'b0, "R6 B drops");
    step(1'b0, 1'b1, "R7 B yellow ignores sensors");
    step(1'b1, 1'b1, "R8 back to A green");
    // both sensors low: quickest cycle
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, "R3 R6 fast rotation");
    // pseudo-random patterns
    lfsr = 8'hA5;
    for (int i = 0; i < 300; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      step(lfsr[0] | lfsr[1], lfsr[2] | lfsr[3], "R8 mixed pattern");
    end
    // mid-run reset from a non-zero state
    step(1'b0, 1'b1, "R3 before reset");
    #(CLK_PERIOD/4);
    rst_n = 1'b0;
    model_st = 0;
    #(CLK_PERIOD/8);
    check("R1 async reset");
    @(negedge clk);
    check("R1 held in reset");
    rst_n = 1'b1;
    step(1'b1, 1'b0, "R2 after reset");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule